// File: doc/BRIEF.md
# Maintain-Power Disconnect Delay Timer

This block decides when a powered port has lost its load and should be switched off. Each port has one instance. The block stays idle until the port is powered and its inrush start period is over. From then on it counts millisecond ticks whenever an external comparator reports port current below the disconnect threshold. When the programmed delay has run out, it issues a single-cycle disconnect request.

Brief dips in load current must not cause a disconnect, and brief bursts of load current must not restart the delay either. The timer reloads to the full delay only after the current has stayed above the threshold for an unbroken window. That window is 13% of the selected delay, rounded to the nearest whole tick. A shorter burst only pauses the countdown.

Top module: `mpd_timer`

## Requirements
- R1: `dly_sel_i` selects the delay in ticks: 2'b00 = 360, 2'b01 = 90, 2'b10 = 180, 2'b11 = 720. Arming happens with `below_i` high and a tick on every cycle. `disc_o` then rises after the edge of exactly that many ticks.
- R2: While `armed_i` is low, the count is held at the full delay and `disc_o` stays low, whatever `below_i` and `tick_i` do.
- R3: The count moves only on a cycle where `armed_i`, `tick_i` and `below_i` are all high. A cycle without a tick does not advance it, and neither does a tick with current above the threshold.
- R4: The count saturates at zero. After a disconnect request, no further request is made for as long as `armed_i` stays high.
- R5: Current can stay above the threshold for a run of ticks with no below-threshold tick in between. If that run reaches the qualification window, the count reloads to the full delay. The window is 47, 12, 23 or 94 ticks for codes 00, 01, 10 and 11 respectively.
- R6: A single below-threshold tick clears the qualification run. An above-threshold run shorter than the window leaves the count where it was.
- R7: `disc_o` is registered and high for exactly one clock cycle per disconnect.
- R8: Dropping `armed_i` for at least one cycle and raising it again restarts the full delay. This applies after a disconnect as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle millisecond tick |
| armed_i | input | 1 | Port powered and inrush start period complete |
| below_i | input | 1 | Port current below disconnect threshold |
| dly_sel_i | input | 2 | Disconnect delay code |
| disc_o | output | 1 | One-cycle disconnect request |

## Verification
The assertions assume three things about the inputs. `dly_sel_i` is changed only while `armed_i` is low. `tick_i` is a clean one-cycle-per-tick strobe. `below_i` holds steady over each clock cycle. The stimulus changes the delay code only during a disarmed cycle before arming, and it sets every input at the falling edge. Most scenarios assert a tick on every cycle so that tick counts and cycle counts line up. One scenario withholds ticks to show that time without ticks does not count toward the delay.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  function automatic int qual_ticks(input int dly, input int pct);
    return (dly * pct + 50) / 100;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/mpd_dly_lut.sv
module mpd_dly_lut #(
  parameter int DLY0  = 360,
  parameter int DLY1  = 90,
  parameter int DLY2  = 180,
  parameter int DLY3  = 720,
  parameter int PCT   = 13,
  parameter int CNT_W = 10
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] full_o,
  output logic [CNT_W-1:0] win_o
);
  localparam int NCODE = 4;

  logic [CNT_W-1:0] full_tab [NCODE];
  logic [CNT_W-1:0] win_tab  [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tab
    localparam int D = (g == 0) ? DLY0 : (g == 1) ? DLY1 : (g == 2) ? DLY2 : DLY3;
    assign full_tab[g] = CNT_W'(D);
    assign win_tab[g]  = CNT_W'(mpd_pkg::qual_ticks(D, PCT));
  end

  assign full_o = full_tab[sel_i];
  assign win_o  = win_tab[sel_i];
endmodule

// File: rtl/mpd_qual_cnt.sv
module mpd_qual_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             tick_i,
  input  logic             below_i,
  input  logic [CNT_W-1:0] win_i,
  output logic             rearm_o
);
  logic [CNT_W-1:0] qual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            qual_q <= '0;
    else if (!armed_i)      qual_q <= '0;
    else if (tick_i) begin
      if (below_i)          qual_q <= '0;
      else if (qual_q < win_i) qual_q <= qual_q + 1'b1;
    end
  end

  // reload strobe on the tick that completes the window
  assign rearm_o = armed_i && tick_i && !below_i && (qual_q == win_i - 1'b1);

  assert_qual_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && tick_i && below_i) |=> (qual_q == '0));

  assert_qual_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_q <= win_i);
endmodule

// File: rtl/mpd_dly_cnt.sv
module mpd_dly_cnt #(
  parameter int CNT_W = 10,
  parameter int RST_FULL = 360
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             tick_i,
  input  logic             below_i,
  input  logic             rearm_i,
  input  logic [CNT_W-1:0] full_i,
  output logic             disc_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             disc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(RST_FULL);
      done_q <= 1'b0;
      disc_q <= 1'b0;
    end else if (!armed_i) begin
      cnt_q  <= full_i;
      done_q <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      disc_q <= 1'b0;
      if (!done_q) begin
        if (rearm_i) begin
          cnt_q <= full_i;
        end else if (tick_i && below_i && cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            disc_q <= 1'b1;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign disc_o = disc_q;

  assert_hold_unarmed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> (cnt_q == $past(full_i)));

  assert_no_tick_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && !tick_i) |=> $stable(cnt_q));

  assert_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && cnt_q == '0) |=> (cnt_q == '0));

  assert_pulse_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_q |-> (cnt_q == '0 && done_q));

  assert_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_q |=> !disc_q);
endmodule

// File: rtl/mpd_timer.sv
module mpd_timer #(
  parameter int DLY0 = 360,
  parameter int DLY1 = 90,
  parameter int DLY2 = 180,
  parameter int DLY3 = 720,
  parameter int QUAL_PCT = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       armed_i,
  input  logic       below_i,
  input  logic [1:0] dly_sel_i,
  output logic       disc_o
);
  localparam int MAX_DLY = mpd_pkg::max4(DLY0, DLY1, DLY2, DLY3);
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  logic [CNT_W-1:0] full;
  logic [CNT_W-1:0] win;
  logic             rearm;

  mpd_dly_lut #(
    .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3),
    .PCT(QUAL_PCT), .CNT_W(CNT_W)
  ) u_lut (
    .sel_i (dly_sel_i),
    .full_o(full),
    .win_o (win)
  );

  mpd_qual_cnt #(.CNT_W(CNT_W)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .armed_i(armed_i),
    .tick_i (tick_i),
    .below_i(below_i),
    .win_i  (win),
    .rearm_o(rearm)
  );

  mpd_dly_cnt #(.CNT_W(CNT_W), .RST_FULL(DLY0)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .armed_i(armed_i),
    .tick_i (tick_i),
    .below_i(below_i),
    .rearm_i(rearm),
    .full_i (full),
    .disc_o (disc_o)
  );

  assert_no_disc_unarmed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> !disc_o);

  assert_rearm_above_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm |-> (armed_i && !below_i));
endmodule

// File: tb/mpd_timer_bench.sv
module mpd_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, armed = 1'b0, below = 1'b0;
  logic [1:0] sel = 2'b00;
  logic disc;

  int n_run = 0, n_fail = 0;
  int pulse_pos, pulse_cnt;

  always #2 clk = ~clk;

  mpd_timer u_mpd_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .armed_i(armed),
    .below_i(below), .dly_sel_i(sel), .disc_o(disc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive n cycles; record first pulse position (1-based) and pulse-high cycles
  task automatic run(input int n, input bit a, input bit b, input bit t);
    pulse_pos = 0;
    pulse_cnt = 0;
    for (int i = 1; i <= n; i++) begin
      armed = a; below = b; tick = t;
      @(posedge clk);
      @(negedge clk);
      if (disc) begin
        pulse_cnt++;
        if (pulse_pos == 0) pulse_pos = i;
      end
    end
  endtask

  task automatic disarm(input logic [1:0] code);
    sel = code;
    run(2, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    check(disc == 1'b0, "R7 reset", int'(disc), 0);
  endtask

  task automatic t_code(input logic [1:0] code, input int d);
    disarm(code);
    run(d + 20, 1'b1, 1'b1, 1'b1);
    check(pulse_pos == d, "R1 delay", pulse_pos, d);
    check(pulse_cnt == 1, "R4 R7 single pulse", pulse_cnt, 1);
  endtask

  task automatic t_unarmed;
    disarm(2'b01);
    run(800, 1'b0, 1'b1, 1'b1);
    check(pulse_cnt == 0, "R2 unarmed", pulse_cnt, 0);
  endtask

  task automatic t_notick;
    disarm(2'b01);
    run(30, 1'b1, 1'b1, 1'b1);
    run(200, 1'b1, 1'b1, 1'b0);
    check(pulse_cnt == 0, "R3 no tick", pulse_cnt, 0);
    run(80, 1'b1, 1'b1, 1'b1);
    check(pulse_pos == 60, "R3 resume", pulse_pos, 60);
  endtask

  task automatic t_burst;
    disarm(2'b01);
    run(40, 1'b1, 1'b1, 1'b1);
    run(11, 1'b1, 1'b0, 1'b1);
    check(pulse_cnt == 0, "R6 burst", pulse_cnt, 0);
    for (int k = 0; k < 5; k++) begin
      run(1, 1'b1, 1'b1, 1'b1);
      run(11, 1'b1, 1'b0, 1'b1);
    end
    check(pulse_cnt == 0, "R6 repeated bursts", pulse_cnt, 0);
    run(60, 1'b1, 1'b1, 1'b1);
    check(pulse_pos == 45, "R6 count kept", pulse_pos, 45);
  endtask

  task automatic t_rearm;
    disarm(2'b01);
    run(40, 1'b1, 1'b1, 1'b1);
    run(12, 1'b1, 1'b0, 1'b1);
    run(100, 1'b1, 1'b1, 1'b1);
    check(pulse_pos == 90, "R5 reload code01", pulse_pos, 90);
  endtask

  task automatic t_round;
    disarm(2'b00);
    run(10, 1'b1, 1'b1, 1'b1);
    run(46, 1'b1, 1'b0, 1'b1);
    run(360, 1'b1, 1'b1, 1'b1);
    check(pulse_pos == 350, "R5 window 47 not reached", pulse_pos, 350);
    disarm(2'b00);
    run(10, 1'b1, 1'b1, 1'b1);
    run(47, 1'b1, 1'b0, 1'b1);
    run(370, 1'b1, 1'b1, 1'b1);
    check(pulse_pos == 360, "R5 window 47 reload", pulse_pos, 360);
    disarm(2'b10);
    run(10, 1'b1, 1'b1, 1'b1);
    run(22, 1'b1, 1'b0, 1'b1);
    run(180, 1'b1, 1'b1, 1'b1);
    check(pulse_pos == 170, "R5 window 23 not reached", pulse_pos, 170);
    disarm(2'b11);
    run(10, 1'b1, 1'b1, 1'b1);
    run(94, 1'b1, 1'b0, 1'b1);
    run(730, 1'b1, 1'b1, 1'b1);
    check(pulse_pos == 720, "R5 window 94 reload", pulse_pos, 720);
  endtask

  task automatic t_hold_done;
    disarm(2'b01);
    run(90, 1'b1, 1'b1, 1'b1);
    check(pulse_pos == 90, "R4 first pulse", pulse_pos, 90);
    run(100, 1'b1, 1'b0, 1'b1);
    run(200, 1'b1, 1'b1, 1'b1);
    check(pulse_cnt == 0, "R4 held after disconnect", pulse_cnt, 0);
  endtask

  task automatic t_repower;
    run(1, 1'b0, 1'b1, 1'b1);
    run(100, 1'b1, 1'b1, 1'b1);
    check(pulse_pos == 90, "R8 repower", pulse_pos, 90);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_code(2'b00, 360);
    t_code(2'b01, 90);
    t_code(2'b10, 180);
    t_code(2'b11, 720);
    t_unarmed();
    t_notick();
    t_burst();
    t_rearm();
    t_round();
    t_hold_done();
    t_repower();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule